// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement numbers of `WIDTH` bits over several clock cycles and returns the full-width signed product. `WIDTH` must be even. Each cycle it handles two multiplier bits. It looks at a three-bit window made of those two bits and the bit just below them, and turns the window into a digit from -2 to +2. The digit picks zero, the multiplicand or twice the multiplicand, and a negative digit turns the add into a subtract. The running sum is then shifted right by two places. No three-times multiple is ever built. The top bit of the multiplier needs no special step at the end, because the recoding already gives it negative weight.

Operands enter through a valid/ready handshake and the product leaves through another. A pair of operands is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the product has been handed over. While the block works or holds a result, anything on `in_valid`, `a_in` or `x_in` is ignored. The result stays on `product` with `out_valid` high for as long as `out_ready` is low. When `out_valid` and `out_ready` are high on the same edge, the block returns to idle.

Top module: `booth4_seq_mult`

## Requirements
- R1: During and right after a synchronous active-low reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Operands are captured only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the product has been taken. Operand and valid changes in that interval do not affect the result.
- R3: `out_valid` rises exactly `WIDTH/2` clock cycles after the capture edge.
- R4: `product` is the exact signed product of `a_in` and `x_in` as captured, written as a 2·`WIDTH`-bit two's-complement value.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `product` is stable. After an edge where both are 1, `out_valid` is 0 and `in_ready` is 1.
- R6: The window {x(i+1), x(i), x(i-1)}, with x(-1) taken as 0, maps to a digit as follows. 000 and 111 give 0. 001 and 010 give +1. 011 gives +2. 100 gives -2. 101 and 110 give -1. At most one of the two multiples is selected per step, and a negative digit always selects a non-zero multiple. Multipliers made of the repeated pairs 10 or 01, or of all ones, must multiply correctly.
- R7: The running sum carries two guard bits. The most negative operands give correct products: min×min = 2^(2·WIDTH-2), and min×(-1) = 2^(WIDTH-1). After every shift, the upper part of the partial product fits in `WIDTH` signed bits.
- R8: `in_ready` and `out_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block is idle and will take an operand pair |
| a_in | input | WIDTH | Signed multiplicand |
| x_in | input | WIDTH | Signed multiplier |
| out_valid | output | 1 | Product is available |
| out_ready | input | 1 | Consumer takes the product |
| product | output | 2*WIDTH | Signed product |

## Verification
Some properties are checked on every cycle by assertions. These are: the handshake sequence (capture leads to busy, the last step leads to holding the result, a stall keeps `out_valid` and `product` unchanged, release returns to idle), the single-multiple rule of the recoder, and the guard-bit bound on the partial product after each shift. Only the bench's scenarios can show that the numbers are right. These cover every signed operand pair at width 6, the most-negative and alternating-bit corner operands at width 16, and random pairs under random valid and back-pressure patterns. They also show that operand changes while busy are truly ignored.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;

  // selection produced from one three-bit multiplier window
  typedef struct packed {
    logic neg;  // subtract the chosen multiple
    logic one;  // choose the multiplicand
    logic two;  // choose twice the multiplicand
  } digit_sel_t;

endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
  import booth4_pkg::*;
(
  input  logic [2:0]  win,   // {x(i+1), x(i), x(i-1)}
  output digit_sel_t  sel
);

  always_comb begin
    sel = '0;
    case (win)
      3'b001, 3'b010: sel.one = 1'b1;
      3'b011:         sel.two = 1'b1;
      3'b100: begin
        sel.neg = 1'b1;
        sel.two = 1'b1;
      end
      3'b101, 3'b110: begin
        sel.neg = 1'b1;
        sel.one = 1'b1;
      end
      default:        sel = '0;  // 000 and 111 give a zero digit
    endcase
  end

  // R6: at most one multiple, and no negative zero
  always_comb begin
    a_r6_single_multiple: assert (!(sel.one && sel.two));
    a_r6_neg_nonzero: assert (!sel.neg || sel.one || sel.two);
  end

endmodule

// File: rtl/booth4_multiple.sv
module booth4_multiple
  import booth4_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = W + 2
) (
  input  logic [W-1:0]  mcand,
  input  digit_sel_t    sel,
  output logic [AW-1:0] addend,
  output logic          cin
);

  logic [AW-1:0] single_m;
  logic [AW-1:0] double_m;
  logic [AW-1:0] mag;

  assign single_m = {{(AW-W){mcand[W-1]}}, mcand};
  assign double_m = {{(AW-W-1){mcand[W-1]}}, mcand, 1'b0};

  always_comb begin
    if (sel.two)      mag = double_m;
    else if (sel.one) mag = single_m;
    else              mag = '0;
  end

  // subtraction as ones' complement plus a carry-in of one
  assign addend = sel.neg ? ~mag : mag;
  assign cin    = sel.neg;

endmodule

// File: rtl/booth4_datapath.sv
module booth4_datapath
  import booth4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   x_in,
  output logic [2*W-1:0] product
);

  localparam int AW = W + 2;  // two guard bits for the +/-2a multiple

  logic [AW-1:0] hi_q;
  logic [W-1:0]  lo_q;    // multiplier bits not yet used, product bits below
  logic [W-1:0]  mc_q;
  logic          xprev_q; // bit just below the current pair
  logic [AW-1:0] addend;
  logic          cin;
  logic [AW-1:0] sum;
  digit_sel_t    sel;

  booth4_recoder u_rec (
    .win ({lo_q[1:0], xprev_q}),
    .sel (sel)
  );

  booth4_multiple #(.W(W), .AW(AW)) u_mult (
    .mcand  (mc_q),
    .sel    (sel),
    .addend (addend),
    .cin    (cin)
  );

  assign sum = hi_q + addend + AW'(cin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      mc_q    <= '0;
      xprev_q <= 1'b0;
    end else if (load) begin
      hi_q    <= '0;
      lo_q    <= x_in;
      mc_q    <= a_in;
      xprev_q <= 1'b0;
    end else if (step) begin
      hi_q    <= {{2{sum[AW-1]}}, sum[AW-1:2]};
      lo_q    <= {sum[1:0], lo_q[W-1:2]};
      xprev_q <= lo_q[1];
    end
  end

  assign product = {hi_q[W-1:0], lo_q};

  // R7: after each shift the upper part fits in W signed bits
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (hi_q[AW-1] == hi_q[W-1]) && (hi_q[AW-2] == hi_q[W-1]));

  // R5: without load or step the product register holds
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(product));

endmodule

// File: rtl/booth4_ctrl.sv
module booth4_ctrl
  import booth4_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic step
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == CW'(STEPS - 1));

  always_comb begin
    st_d = st_q;
    case (st_q)
      SEQ_IDLE: if (in_valid)  st_d = SEQ_RUN;
      SEQ_RUN:  if (last)      st_d = SEQ_HOLD;
      SEQ_HOLD: if (out_ready) st_d = SEQ_IDLE;
      default:                 st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_q == SEQ_RUN) ? cnt_q + 1'b1 : '0;
    end
  end

  assign in_ready  = (st_q == SEQ_IDLE);
  assign out_valid = (st_q == SEQ_HOLD);
  assign load      = in_ready && in_valid;
  assign step      = (st_q == SEQ_RUN);

  // R2: a capture makes the block busy
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!in_ready && step));

  // R3: the final step leads straight to a held result
  a_r3_last_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> out_valid);

  // R3: the result is not offered before the final step
  a_r3_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> !out_valid);

  // R5: a stalled result stays offered
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R5: a taken result frees the input side
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

endmodule

// File: rtl/booth4_seq_mult.sv
module booth4_seq_mult
  import booth4_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WIDTH-1:0]   a_in,
  input  logic [WIDTH-1:0]   x_in,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2*WIDTH-1:0] product
);

  localparam int STEPS = WIDTH / 2;

  logic load;
  logic step;

  booth4_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .step      (step)
  );

  booth4_datapath #(.W(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .a_in    (a_in),
    .x_in    (x_in),
    .product (product)
  );

  // R5: product stable while the consumer stalls
  a_r5_product_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(product));

  // R8: idle and result-held are never shown together
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

endmodule

// File: tb/sim_booth4_seq_mult.sv
module sim_booth4_lane #(
  parameter int W      = 6,
  parameter int NPAIRS = 4096,
  parameter bit EXH    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output logic finished,
  output int   vecs,
  output int   errs
);

  localparam int S = W / 2;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = ~MINV;

  logic           in_valid, out_ready;
  logic [W-1:0]   a_drv, x_drv;
  logic           in_ready, out_valid;
  logic [2*W-1:0] prod;

  booth4_seq_mult #(.WIDTH(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .a_in      (a_drv),
    .x_in      (x_drv),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .product   (prod)
  );

  // behavioural reference: 0 idle, 1 working, 2 holding
  int             mmode = 0;
  int             mcnt = 0;
  logic [2*W-1:0] mexp;
  logic           macc = 1'b0;
  logic           mstall = 1'b0;
  string          mtag = "R4";
  int             idx;

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] x);
    longint sa = longint'($signed(a));
    longint sx = longint'($signed(x));
    longint p  = sa * sx;
    return p[2*W-1:0];
  endfunction

  function automatic string tag_of(logic [W-1:0] a, logic [W-1:0] x);
    if (a == MINV || x == MINV) return "R7";
    if (x == {S{2'b10}} || x == {S{2'b01}} || x == {W{1'b1}}) return "R6";
    return "R4";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mmode  <= 0;
      mcnt   <= 0;
      macc   <= 1'b0;
      mstall <= 1'b0;
    end else begin
      macc   <= 1'b0;
      mstall <= 1'b0;
      case (mmode)
        0: if (in_valid) begin
          mexp  <= ref_mul(a_drv, x_drv);
          mtag  <= tag_of(a_drv, x_drv);
          mmode <= 1;
          mcnt  <= 0;
          macc  <= 1'b1;
        end
        1: begin
          if (mcnt == S - 1) mmode <= 2;
          mcnt <= mcnt + 1;
        end
        default: if (out_ready) mmode <= 0; else mstall <= 1'b1;
      endcase
    end
  end

  task automatic fail(string tag, string what, logic [2*W-1:0] got, logic [2*W-1:0] exp);
    errs++;
    $display("FAIL %s W=%0d %s: got %h expected %h", tag, W, what, got, exp);
  endtask

  task automatic compare();
    logic exp_ir, exp_ov;
    exp_ir = (mmode == 0);
    exp_ov = (mmode == 2);
    vecs++;
    if (in_ready !== exp_ir) fail(rst_n ? "R2" : "R1", "in_ready", 2*W'(in_ready), 2*W'(exp_ir));
    if (out_valid !== exp_ov) fail(rst_n ? "R3" : "R1", "out_valid", 2*W'(out_valid), 2*W'(exp_ov));
    if (in_ready === 1'b1 && out_valid === 1'b1) fail("R8", "ready with valid", 1, 0);
    if (exp_ov && prod !== mexp) fail(mstall ? "R5" : mtag, "product", prod, mexp);
  endtask

  task automatic pick(int n, output logic [W-1:0] a, output logic [W-1:0] x);
    if (EXH) begin
      a = W'(n);
      x = W'(n >> W);
    end else begin
      case (n)
        0: begin a = MINV; x = MINV; end
        1: begin a = MINV; x = MAXV; end
        2: begin a = MAXV; x = MAXV; end
        3: begin a = MINV; x = {W{1'b1}}; end
        4: begin a = {W{1'b1}}; x = {W{1'b1}}; end
        5: begin a = MAXV; x = {S{2'b10}}; end
        6: begin a = W'(32'h5a3c_9e17); x = {S{2'b01}}; end
        7: begin a = '0; x = MINV; end
        default: begin a = W'($urandom); x = W'($urandom); end
      endcase
    end
  endtask

  initial begin
    in_valid  = 1'b0;
    out_ready = 1'b0;
    a_drv     = '0;
    x_drv     = '0;
    finished  = 1'b0;
    vecs      = 0;
    errs      = 0;
    idx       = 0;
    // R1: reset state seen while reset is held
    repeat (2) @(negedge clk);
    compare();
    wait (rst_n === 1'b1);
    while (!(idx >= NPAIRS && mmode == 0)) begin
      @(negedge clk);
      compare();
      if (macc) idx++;
      out_ready = ($urandom % 3) != 0;
      if (mmode == 0 && idx < NPAIRS) begin
        in_valid = ($urandom % 4) != 0;
        pick(idx, a_drv, x_drv);
      end else if (mmode != 0) begin
        // R2: noise on the input side while busy must be ignored
        in_valid = ($urandom % 2) != 0;
        a_drv    = W'($urandom);
        x_drv    = W'($urandom);
      end else begin
        in_valid = 1'b0;
      end
    end
    finished = 1'b1;
  end

endmodule

module sim_booth4_seq_mult;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f6, f16;
  int   v6, e6, v16, e16;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sim_booth4_lane #(.W(6),  .NPAIRS(4096), .EXH(1'b1)) l6 (
    .clk (clk), .rst_n (rst_n), .finished (f6), .vecs (v6), .errs (e6));

  sim_booth4_lane #(.W(16), .NPAIRS(1500), .EXH(1'b0)) l16 (
    .clk (clk), .rst_n (rst_n), .finished (f16), .vecs (v16), .errs (e16));

  initial begin
    int cyc = 0;
    int wd  = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    while (!(f6 === 1'b1 && f16 === 1'b1) && cyc < WD_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!(f6 === 1'b1 && f16 === 1'b1)) begin
      wd = 1;
      $display("FAIL R3 watchdog: got no completion after %0d cycles expected completion", cyc);
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", v6 + v16 + wd, e6 + e16 + wd);
    $finish;
  end

endmodule